// File: doc/BRIEF.md
# Serial Channel Control and Status

This block is one character-level channel of a dual asynchronous serial controller, seen from an 8-bit register bus. Software configures two mode registers through a single address, using a pointer that advances on each access. It issues enable, disable and reset commands through a command register, reads a status byte, pops received characters from a small FIFO, and writes characters into a transmit holding register.

The receive side takes characters that are already deserialized, each with parity-error, framing-error and break tags, on a one-cycle valid strobe. The transmit side passes characters to an external shifter through a ready/valid pair. The shifter reports that it is busy so that the block can derive a transmitter-empty flag and time the start of a break. Bit-level serialization and baud-rate generation happen outside this block.

Bus accesses take effect at the clock edge where `bus_sel_i` is high. Read data and status are combinational from the current state.

Top module: `serial_chan_ctrl`

## Requirements
- R1: After reset, the status byte (address 1) reads 0Ch: bits 2 and 3 are set and all others are clear. The mode pointer selects mode register 1, both receiver and transmitter are disabled, and `tx_valid_o`, `tx_brk_o`, `tx_mark_o`, `rx_irq_o` and `brk_chg_o` are low.
- R2: The first access to address 0 reaches mode register 1 and every later access reaches mode register 2. A command write with bits 6-4 = 1 returns the pointer to mode register 1.
- R3: Command bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If both bits of a pair are set, disable wins. Characters that arrive while the receiver is disabled are discarded.
- R4: The receive FIFO holds 3 characters in arrival order. A read of address 3 pops the oldest character, and an empty FIFO reads 00h. Status bit 0 means one or more characters are held; bit 1 means three are held.
- R5: A character that arrives while the FIFO is full waits in a shift stage and enters the FIFO after the next pop. A further arrival while that stage is occupied replaces the stage character and sets status bit 4 (overrun).
- R6: Each accepted character ORs its tags into sticky status bits: bit 7 for break, bit 6 for framing error, bit 5 for parity error. Command code 4 (bits 6-4) clears bits 7-4.
- R7: Command code 2 flushes the FIFO and the shift stage and disables the receiver.
- R8: A write of address 3 loads the holding register and clears status bit 2. The character appears on `tx_valid_o`/`tx_char_o` only while the transmitter is enabled, and a handshake empties the holding register. Status bit 3 is set only when the holding register is empty and `tx_busy_i` is low.
- R9: Command code 3 drops any held character and disables the transmitter.
- R10: Command code 6 raises `tx_brk_o` once `tx_busy_i` is low and blocks `tx_valid_o` from the command onward. Command code 7 clears the break and pulses `tx_mark_o` for one cycle, and normal transmission resumes in the following cycle.
- R11: `rx_irq_o` follows status bit 0 when mode register 1 bit 6 is 0, and follows status bit 1 when it is 1.
- R12: `brk_chg_o` sets when an accepted character carries the break tag. Only command code 5 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 mode, 1 status, 2 command, 3 data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error tag |
| rx_ferr_i | input | 1 | Framing error tag |
| rx_brk_i | input | 1 | Break tag |
| rx_irq_o | output | 1 | Receive interrupt request |
| brk_chg_o | output | 1 | Break-change flag |
| tx_valid_o | output | 1 | Character offered to shifter |
| tx_char_o | output | 8 | Character to shifter |
| tx_ready_i | input | 1 | Shifter accepts character |
| tx_busy_i | input | 1 | Shifter is serializing |
| tx_brk_o | output | 1 | Hold the line low |
| tx_mark_o | output | 1 | Send one high bit |

## Verification
A write, pop, received character or handshake changes state at the edge where it is presented. Status, read data and the transmit outputs then show the new value in that same post-edge cycle, with no extra latency. The bench drives inputs just after a rising edge, and the scoreboard samples read data at the falling edge of an access cycle, so every read reflects the state before its own pop or pointer advance. Port checks run one step after the edge that carries the stimulus. The break sequence is checked cycle by cycle: the break rises one edge after `tx_busy_i` falls, the mark pulse lasts one edge after the stop command, and the character returns at the edge after that.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;
  typedef enum logic [2:0] {
    MC_NOP       = 3'd0,
    MC_PTR_RST   = 3'd1,
    MC_RX_RST    = 3'd2,
    MC_TX_RST    = 3'd3,
    MC_ERR_CLR   = 3'd4,
    MC_BCHG_CLR  = 3'd5,
    MC_BRK_START = 3'd6,
    MC_BRK_STOP  = 3'd7
  } misc_cmd_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;
endpackage

// File: rtl/serial_chan_rxbuf.sv
module serial_chan_rxbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          ovr_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] stg_q, stg_d;
  logic          stg_v_q, stg_v_d;
  logic          ovr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    cnt_d   = cnt_q;
    stg_d   = stg_q;
    stg_v_d = stg_v_q;
    ovr     = 1'b0;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
      cnt_d = cnt_q - CW'(1);
      if (stg_v_q) begin
        mem_d[IW'(cnt_d)] = stg_q;
        cnt_d   = cnt_d + CW'(1);
        stg_v_d = 1'b0;
      end
    end
    if (push_i) begin
      if (cnt_d < CW'(DEPTH)) begin
        mem_d[IW'(cnt_d)] = push_data_i;
        cnt_d = cnt_d + CW'(1);
      end else begin
        ovr     = stg_v_d;   // stage still occupied: replace it
        stg_d   = push_data_i;
        stg_v_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q   <= '0;
      stg_q   <= '0;
      stg_v_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q   <= '0;
      stg_v_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      cnt_q   <= cnt_d;
      stg_q   <= stg_d;
      stg_v_q <= stg_v_d;
    end
  end

  assign head_o  = (cnt_q != '0) ? mem_q[0] : '0;
  assign count_o = cnt_q;
  assign ovr_o   = ovr & ~flush_i;

  p_pop_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q != '0 && !push_i && !stg_v_q && !flush_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  p_ovr_when_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (stg_v_q && cnt_q == CW'(DEPTH)));

  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && !stg_v_q));
endmodule

// File: rtl/serial_chan_tx.sv
module serial_chan_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reset_i,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          brk_start_i,
  input  logic          brk_stop_i,
  input  logic          tx_ready_i,
  input  logic          tx_busy_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_char_o,
  output logic          thr_empty_o,
  output logic          brk_o,
  output logic          mark_o
);
  logic [DW-1:0] thr_q;
  logic          thr_v_q, brk_pend_q, brk_act_q, mark_q;

  assign tx_valid_o  = thr_v_q & en_i & ~brk_pend_q & ~brk_act_q & ~mark_q;
  assign tx_char_o   = thr_q;
  assign thr_empty_o = ~thr_v_q;
  assign brk_o       = brk_act_q;
  assign mark_o      = mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      thr_v_q    <= 1'b0;
      brk_pend_q <= 1'b0;
      brk_act_q  <= 1'b0;
      mark_q     <= 1'b0;
    end else if (reset_i) begin
      thr_v_q    <= 1'b0;
      brk_pend_q <= 1'b0;
      brk_act_q  <= 1'b0;
      mark_q     <= 1'b0;
    end else begin
      if (tx_valid_o && tx_ready_i) thr_v_q <= 1'b0;
      if (wr_i) begin
        thr_q   <= wdata_i;
        thr_v_q <= 1'b1;
      end
      mark_q <= 1'b0;
      if (brk_start_i && !brk_act_q) brk_pend_q <= 1'b1;
      else if (brk_pend_q && !tx_busy_i && !brk_stop_i) begin
        brk_pend_q <= 1'b0;    // current character finished
        brk_act_q  <= 1'b1;
      end
      if (brk_stop_i) begin
        brk_pend_q <= 1'b0;
        if (brk_act_q) begin
          brk_act_q <= 1'b0;
          mark_q    <= 1'b1;
        end
      end
    end
  end

  p_thr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_v_q && !(tx_valid_o && tx_ready_i) && !reset_i) |=> thr_v_q);

  p_brk_after_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> $past(!tx_busy_i));

  p_mark_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |=> !mark_o);

  p_char_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !wr_i) |=> $stable(tx_char_o));
endmodule

// File: rtl/serial_chan_ctrl.sv
module serial_chan_ctrl
  import serial_chan_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 3,
  parameter int FULL_LEVEL = 3,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_char_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          rx_brk_i,
  output logic          rx_irq_o,
  output logic          brk_chg_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_char_o,
  input  logic          tx_ready_i,
  input  logic          tx_busy_i,
  output logic          tx_brk_o,
  output logic          tx_mark_o
);
  logic      bus_wr, bus_rd, cmd_wr, mode_acc;
  misc_cmd_e misc;
  logic [7:0] mr1_q, mr2_q;
  logic      ptr_q, rx_en_q, tx_en_q;
  logic      e_brk_q, e_fe_q, e_pe_q, e_ovr_q, bchg_q;
  logic      rx_push, rx_pop, rx_flush, rx_ovr;
  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_cnt;
  logic      thr_empty, rx_full, rx_nempty, err_clr;
  logic [7:0] status;

  assign bus_wr   = bus_sel_i & bus_wr_i;
  assign bus_rd   = bus_sel_i & ~bus_wr_i;
  assign cmd_wr   = bus_wr & (bus_addr_i == A_CMD);
  assign mode_acc = bus_sel_i & (bus_addr_i == A_MODE);
  assign misc     = misc_cmd_e'(bus_wdata_i[6:4]);
  assign err_clr  = cmd_wr & (misc == MC_ERR_CLR);

  // mode registers behind one address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
      mr1_q <= '0;
      mr2_q <= '0;
    end else begin
      if (bus_wr && mode_acc) begin
        if (ptr_q) mr2_q <= bus_wdata_i;
        else       mr1_q <= bus_wdata_i;
      end
      if (cmd_wr && misc == MC_PTR_RST) ptr_q <= 1'b0;
      else if (mode_acc)                ptr_q <= 1'b1;
    end
  end

  // enables: reset command, then disable, then enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else if (cmd_wr) begin
      if (misc == MC_RX_RST || bus_wdata_i[1]) rx_en_q <= 1'b0;
      else if (bus_wdata_i[0])                 rx_en_q <= 1'b1;
      if (misc == MC_TX_RST || bus_wdata_i[3]) tx_en_q <= 1'b0;
      else if (bus_wdata_i[2])                 tx_en_q <= 1'b1;
    end
  end

  assign rx_flush = cmd_wr & (misc == MC_RX_RST);
  assign rx_push  = rx_valid_i & rx_en_q & ~rx_flush;
  assign rx_pop   = bus_rd & (bus_addr_i == A_DATA);

  serial_chan_rxbuf #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (rx_flush),
    .push_i      (rx_push),
    .push_data_i (rx_char_i),
    .pop_i       (rx_pop),
    .head_o      (rx_head),
    .count_o     (rx_cnt),
    .ovr_o       (rx_ovr)
  );

  // sticky error flags; a new event in the clear cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_brk_q <= 1'b0;
      e_fe_q  <= 1'b0;
      e_pe_q  <= 1'b0;
      e_ovr_q <= 1'b0;
      bchg_q  <= 1'b0;
    end else begin
      e_brk_q <= (e_brk_q & ~err_clr) | (rx_push & rx_brk_i);
      e_fe_q  <= (e_fe_q  & ~err_clr) | (rx_push & rx_ferr_i);
      e_pe_q  <= (e_pe_q  & ~err_clr) | (rx_push & rx_perr_i);
      e_ovr_q <= (e_ovr_q & ~err_clr) | rx_ovr;
      bchg_q  <= (bchg_q & ~(cmd_wr & (misc == MC_BCHG_CLR))) | (rx_push & rx_brk_i);
    end
  end

  serial_chan_tx #(.DW(DW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reset_i     (cmd_wr & (misc == MC_TX_RST)),
    .en_i        (tx_en_q),
    .wr_i        (bus_wr & (bus_addr_i == A_DATA)),
    .wdata_i     (bus_wdata_i[DW-1:0]),
    .brk_start_i (cmd_wr & (misc == MC_BRK_START)),
    .brk_stop_i  (cmd_wr & (misc == MC_BRK_STOP)),
    .tx_ready_i  (tx_ready_i),
    .tx_busy_i   (tx_busy_i),
    .tx_valid_o  (tx_valid_o),
    .tx_char_o   (tx_char_o),
    .thr_empty_o (thr_empty),
    .brk_o       (tx_brk_o),
    .mark_o      (tx_mark_o)
  );

  assign rx_full   = rx_cnt >= CW'(FULL_LEVEL);
  assign rx_nempty = rx_cnt != '0;
  assign status    = {e_brk_q, e_fe_q, e_pe_q, e_ovr_q,
                      thr_empty & ~tx_busy_i, thr_empty, rx_full, rx_nempty};

  always_comb begin
    unique case (bus_addr_i)
      A_MODE:  bus_rdata_o = ptr_q ? mr2_q : mr1_q;
      A_STAT:  bus_rdata_o = status;
      A_CMD:   bus_rdata_o = '0;
      default: bus_rdata_o = 8'(rx_head);
    endcase
  end

  assign rx_irq_o  = mr1_q[6] ? rx_full : rx_nempty;
  assign brk_chg_o = bchg_q;

  p_ptr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q && !(cmd_wr && misc == MC_PTR_RST)) |=> ptr_q);

  p_rx_off_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_q && !rx_flush) |=> (rx_cnt <= $past(rx_cnt)));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_pe_q && !err_clr) |=> e_pe_q);

  p_bchg_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bchg_q && !(cmd_wr && misc == MC_BCHG_CLR)) |=> bchg_q);
endmodule

// File: tb/serial_chan_ctrl_test.sv
module serial_chan_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_char = 0;
  logic rx_irq, brk_chg, tx_valid, tx_brk, tx_mark;
  logic [7:0] tx_char;
  logic tx_ready = 0, tx_busy = 0;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_chan_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_valid_i(rx_valid), .rx_char_i(rx_char), .rx_perr_i(rx_perr),
    .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk), .rx_irq_o(rx_irq),
    .brk_chg_o(brk_chg), .tx_valid_o(tx_valid), .tx_char_o(tx_char),
    .tx_ready_i(tx_ready), .tx_busy_i(tx_busy), .tx_brk_o(tx_brk),
    .tx_mark_o(tx_mark)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: reads sampled mid-cycle
  always @(negedge clk) begin
    if (bus_sel && !bus_wr && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_op(input logic wr, input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_op(1'b0, a, 8'h00);
  endtask

  task automatic rx_put(input logic [7:0] c, input logic pe, input logic fe, input logic bk);
    rx_valid = 1; rx_char = c; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    step();
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1;
    step();
    // R1 reset state
    rd_exp(1, 8'h0C, "R1 status");
    chk({7'b0, tx_valid}, 0, "R1 tx_valid");
    chk({6'b0, tx_brk, tx_mark}, 0, "R1 brk/mark");
    chk({6'b0, rx_irq, brk_chg}, 0, "R1 irq/bchg");
    rd_exp(0, 8'h00, "R1 mode1 first");
    // R2 mode pointer (pointer now at mode 2)
    bus_op(1, 0, 8'h27);
    rd_exp(0, 8'h27, "R2 mode2");
    bus_op(1, 2, 8'h10);
    bus_op(1, 0, 8'h13);
    rd_exp(0, 8'h27, "R2 after mode1 write");
    bus_op(1, 2, 8'h10);
    rd_exp(0, 8'h13, "R2 pointer reset");
    // R3 receiver disabled drops chars; disable wins
    rx_put(8'h41, 0, 0, 0);
    rd_exp(1, 8'h0C, "R3 disabled drop");
    bus_op(1, 2, 8'h03);
    rx_put(8'h42, 0, 0, 0);
    rd_exp(1, 8'h0C, "R3 disable wins");
    bus_op(1, 2, 8'h01);
    // R4 FIFO order and flags, R11 irq select
    rx_put(8'h11, 0, 0, 0);
    chk({7'b0, rx_irq}, 1, "R11 irq nonempty mode");
    rx_put(8'h22, 0, 0, 0);
    rx_put(8'h33, 0, 0, 0);
    rd_exp(1, 8'h0F, "R4 full status");
    bus_op(1, 2, 8'h10);
    bus_op(1, 0, 8'h53);
    chk({7'b0, rx_irq}, 1, "R11 irq full mode at 3");
    rd_exp(3, 8'h11, "R4 pop first");
    chk({7'b0, rx_irq}, 0, "R11 irq full mode at 2");
    rd_exp(1, 8'h0D, "R4 status two held");
    rd_exp(3, 8'h22, "R4 pop second");
    rd_exp(3, 8'h33, "R4 pop third");
    rd_exp(3, 8'h00, "R4 empty reads zero");
    rd_exp(1, 8'h0C, "R4 empty status");
    // R5 stage and overrun
    rx_put(8'hA1, 0, 0, 0);
    rx_put(8'hA2, 0, 0, 0);
    rx_put(8'hA3, 0, 0, 0);
    rx_put(8'hA4, 0, 0, 0);
    rd_exp(1, 8'h0F, "R5 stage no overrun");
    rx_put(8'hA5, 0, 0, 0);
    rd_exp(1, 8'h1F, "R5 overrun set");
    rd_exp(3, 8'hA1, "R5 pop A1");
    rd_exp(1, 8'h1F, "R5 stage refills fifo");
    rd_exp(3, 8'hA2, "R5 pop A2");
    rd_exp(3, 8'hA3, "R5 pop A3");
    rd_exp(3, 8'hA5, "R5 replaced stage char");
    rd_exp(3, 8'h00, "R5 drained");
    // R6 sticky errors, R12 break change
    bus_op(1, 2, 8'h40);
    rd_exp(1, 8'h0C, "R6 clear overrun");
    rx_put(8'h01, 1, 0, 0);
    rd_exp(1, 8'h2D, "R6 parity");
    rx_put(8'h02, 0, 1, 0);
    rd_exp(1, 8'h6D, "R6 framing");
    chk({7'b0, brk_chg}, 0, "R12 no break yet");
    rx_put(8'h00, 0, 0, 1);
    rd_exp(1, 8'hEF, "R6 break");
    chk({7'b0, brk_chg}, 1, "R12 break change set");
    bus_op(1, 2, 8'h40);
    rd_exp(1, 8'h0F, "R6 error clear");
    chk({7'b0, brk_chg}, 1, "R12 survives code 4");
    bus_op(1, 2, 8'h50);
    chk({7'b0, brk_chg}, 0, "R12 cleared by code 5");
    // R7 receiver reset
    bus_op(1, 2, 8'h20);
    rd_exp(1, 8'h0C, "R7 flushed");
    rx_put(8'h55, 0, 0, 0);
    rd_exp(1, 8'h0C, "R7 rx disabled");
    // R8 transmit holding
    bus_op(1, 3, 8'h5A);
    rd_exp(1, 8'h00, "R8 holding full");
    chk({7'b0, tx_valid}, 0, "R8 held while disabled");
    bus_op(1, 2, 8'h04);
    chk({7'b0, tx_valid}, 1, "R8 offered when enabled");
    chk(tx_char, 8'h5A, "R8 char");
    tx_ready = 1; step(); tx_ready = 0;
    chk({7'b0, tx_valid}, 0, "R8 handshake empties");
    tx_busy = 1; #1;
    rd_exp(1, 8'h04, "R8 shifter busy");
    tx_busy = 0;
    // R9 transmitter reset
    bus_op(1, 3, 8'h66);
    chk({7'b0, tx_valid}, 1, "R9 before reset");
    bus_op(1, 2, 8'h30);
    chk({7'b0, tx_valid}, 0, "R9 dropped");
    rd_exp(1, 8'h0C, "R9 status");
    bus_op(1, 2, 8'h04);
    chk({7'b0, tx_valid}, 0, "R9 nothing after enable");
    // R10 break
    bus_op(1, 3, 8'h77);
    tx_busy = 1;
    bus_op(1, 2, 8'h60);
    chk({6'b0, tx_valid, tx_brk}, 0, "R10 pending while busy");
    tx_busy = 0;
    step();
    chk({6'b0, tx_valid, tx_brk}, 1, "R10 break active");
    bus_op(1, 2, 8'h70);
    chk({5'b0, tx_valid, tx_brk, tx_mark}, 1, "R10 mark pulse");
    step();
    chk({5'b0, tx_valid, tx_brk, tx_mark}, 4, "R10 resume");
    chk(tx_char, 8'h77, "R10 char kept");
    tx_ready = 1; step(); tx_ready = 0;
    step();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule